// File: doc/BRIEF.md
# Shared-Sum Threshold Parity Unit

This block computes the parity (exclusive-OR) of an N-bit input word with a two-layer network of linear threshold gates. The first layer has N gates that all see the same unit-weight sum of the inputs, so that sum is formed once as a population count. Each of those gates compares the count against its own threshold, k = 1..N. The N comparison bits feed a single second-layer gate, which gives N+1 threshold gates in total.

The second-layer gate weighs first-layer gate k by +1 when k is odd and by -1 when k is even, and uses a threshold of 1. The first-layer outputs form a thermometer code of the count, so the alternating sum is 1 exactly when the count is odd. The result is registered. An input word qualified by `in_valid` produces a valid parity on the next cycle.

Top module: `parity_thresh_net`

## Requirements
- R1: `out_valid` is high in the cycle after an edge at which `in_valid` was sampled high, and low in the cycle after an edge at which `in_valid` was sampled low.
- R2: While synchronous active-high `rst` is sampled high, `out_valid` and `out_parity` both become 0.
- R3: When `in_valid` is sampled high, `out_parity` in the next cycle equals the XOR of all bits of `in_bits` (1 = odd number of ones).
- R4: An all-zero input word gives `out_parity` = 0.
- R5: An all-ones input word gives `out_parity` = N mod 2.
- R6: First-layer gate k (k = 1..N) is high exactly when the number of ones in `in_bits` is at least k, so the count of high gates equals the number of ones.
- R7: When `in_valid` is sampled low, `out_parity` keeps its previous value.
- R8: The second-layer alternating sum (+1 for odd k, -1 for even k) is always 0 or 1, and the output is 1 exactly when that sum minus the threshold 1 is non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_bits` |
| in_bits | input | N | Input word |
| out_valid | output | 1 | Registered; high one cycle after `in_valid` |
| out_parity | output | 1 | Registered parity of the last valid word |

## Verification
On every cycle the assertions check the one-cycle valid latency, the hold of the output when no word is presented, and the match between the registered result and the XOR of the previous valid word. They also check that the number of high first-layer gates equals the population count, and that the alternating second-layer sum stays in {0, 1}. Only the bench scenarios can show the reset values, the all-zero and all-ones corner words, every one of the 2^N input words, and the correct pairing of results with words across gaps in `in_valid`.

// File: rtl/ptn_pkg.sv
package ptn_pkg;
  // bits needed to hold a count from 0 to n
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ptn_popcount.sv
module ptn_popcount #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [N-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  // shared unit-weight sum used by every first-layer gate
  always_comb begin
    count_o = '0;
    for (int i = 0; i < N; i++) count_o = count_o + CW'(bits_i[i]);
  end
endmodule

// File: rtl/ptn_layer1.sv
module ptn_layer1 #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [CW-1:0] count_i,
  output logic [N-1:0]  ge_o
);
  // gate k (bit k-1) fires when count - k >= 0
  for (genvar k = 1; k <= N; k++) begin : g_gate
    assign ge_o[k-1] = (count_i >= CW'(k));
  end
endmodule

// File: rtl/ptn_layer2.sv
module ptn_layer2 #(
  parameter int N  = 8,
  parameter int SW = 6
) (
  input  logic [N-1:0]  ge_i,
  output logic [SW-1:0] sum_o,
  output logic          par_o
);
  logic [SW-1:0] diff;

  // two's-complement accumulation: +1 for odd k, -1 for even k
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) begin
      if ((i % 2) == 0) sum_o = sum_o + SW'(ge_i[i]);
      else              sum_o = sum_o - SW'(ge_i[i]);
    end
    diff  = sum_o - SW'(1);
    par_o = ~diff[SW-1];
  end
endmodule

// File: rtl/parity_thresh_net.sv
module parity_thresh_net #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [N-1:0] in_bits,
  output logic         out_valid,
  output logic         out_parity
);
  localparam int CW = ptn_pkg::cnt_width(N);
  localparam int SW = CW + 2;

  logic [CW-1:0] pop;
  logic [N-1:0]  ge;
  logic [SW-1:0] alt_sum;
  logic          par_c;

  ptn_popcount #(.N(N), .CW(CW)) u_pop (.bits_i(in_bits), .count_o(pop));
  ptn_layer1   #(.N(N), .CW(CW)) u_l1  (.count_i(pop), .ge_o(ge));
  ptn_layer2   #(.N(N), .SW(SW)) u_l2  (.ge_i(ge), .sum_o(alt_sum), .par_o(par_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_parity <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_parity <= par_c;
    end
  end

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_parity_match_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_parity == $past(^in_bits)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_parity));
  assert_thermo_count_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ($countones(ge) == int'(pop)));
  assert_alt_sum_range_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((alt_sum == SW'(0)) || (alt_sum == SW'(1))));
endmodule

// File: tb/parity_thresh_net_bench.sv
module parity_thresh_net_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [N-1:0] in_bits;
  logic         out_valid;
  logic         out_parity;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit [0:0] exp_q[$];
  bit last_par = 1'b0;

  always #2.5 clk = ~clk;

  parity_thresh_net #(.N(N)) u_parity_thresh_net (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(out_valid), .out_parity(out_parity));

  // driver: presents one word at a negedge and records the expectation
  task automatic drive(input logic [N-1:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_bits  = w;
    exp_q.push_back(^w);
  endtask

  task automatic idle(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_bits  = '1;
    end
  endtask

  // monitor: compares results against the scoreboard at negedges
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R1: out_valid=1 with nothing outstanding, expected 0");
        end else begin
          bit e;
          e = exp_q.pop_front();
          if (out_parity !== e) begin
            n_fail++;
            $display("FAIL R3/R6/R8: out_parity=%0b expected %0b", out_parity, e);
          end
          last_par = e;
        end
      end else if (in_valid === 1'b0) begin
        // R7: output held while idle
        n_checks++;
        if (out_parity !== last_par) begin
          n_fail++;
          $display("FAIL R7: out_parity=%0b expected held %0b", out_parity, last_par);
        end
      end
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_bits = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_parity !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: valid=%0b parity=%0b expected 0 0", out_valid, out_parity);
    end
    rst = 1'b0;
    idle(2);
    // R4: all-zero word
    drive('0);
    idle(1);
    // R5: all-ones word, parity N mod 2
    drive('1);
    idle(3);
    // R1/R3: exhaustive back-to-back
    for (int v = 0; v < (1 << N); v++) drive(N'(v));
    idle(2);
    // gapped traffic, odd then idle to exercise R7 hold
    for (int v = 0; v < 64; v++) begin
      drive(N'(v * 37 + 11));
      if (v % 3 == 0) idle(v % 4 + 1);
    end
    idle(4);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL R1: watchdog expired, outputs stalled, expected completion");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule